// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch RAM

This block is the 128-byte internal data store of an 8-bit microcontroller core. Data can be reached in four ways. The first is a plain byte port addressed directly. The second is a register port that names one of eight working registers, R0 to R7. The third is a bit port that reads or changes a single bit. The fourth is a pair of stack helpers that move a hardware stack pointer.

The lowest 32 bytes hold four groups of eight working registers. The register port reaches the group chosen by two bits of the status word that the core supplies, so the core changes context by changing those two bits. Bytes 20h to 2Fh also answer to a 7-bit bit address.

The contents of R0 and R1 in the active group are always driven out, so that the core can use them as indirect pointers. All reads are registered, with one cycle of latency. All writes that arrive in the same cycle take effect together on one clock edge, under a fixed priority.

Top module: `scratch_ram_core`

## Requirements
- R1: A synchronous active-low reset clears every byte to 00h. It also clears all registered read outputs and loads 07h into the stack pointer.
- R2: The byte port reads `mem[byte_addr]` onto `byte_rdata` one cycle later. A write in the same cycle to the same address returns the old value. `byte_we` stores `byte_wdata` at `byte_addr` on the clock edge.
- R3: Register number n addresses byte {status[4], status[3], n[2:0]}. A read appears one cycle later and `reg_we` writes that byte.
- R4: `ptr0` and `ptr1` always show the bytes at {status[4:3],000} and {status[4:3],001}, taken from the current contents.
- R5: Bit address b selects bit b[2:0] of byte 20h + b[6:3]. That bit appears on `bit_rdata` one cycle later.
- R6: `bit_op` encodes 01 = set, 10 = clear and 11 = load `bit_wval`. The operation takes one cycle and leaves the other seven bits of the byte unchanged.
- R7: When several writes target the same byte in one cycle, the priority is byte port, then register port, then push, then bit operation.
- R8: A push first increments the stack pointer and then writes `push_data` at the new pointer.
- R9: A pop places `mem[sp]` on `pop_data` one cycle later and then decrements the pointer. `pop_data` holds its value when no pop occurs.
- R10: The stack pointer wraps modulo 128 in both directions.
- R11: When push and pop are asserted together, only the push acts. The pop is ignored and `pop_data` holds.
- R12: `bit_op` 00 changes no byte, whatever the value of `bit_wval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| status | input | 8 | Status word; bits 4:3 choose the register group |
| byte_addr | input | 7 | Direct byte address |
| byte_we | input | 1 | Byte write enable |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Registered byte read data |
| reg_sel | input | 3 | Register number R0..R7 |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered register read data |
| ptr0 | output | 8 | Current R0 of the active group |
| ptr1 | output | 8 | Current R1 of the active group |
| bit_addr | input | 7 | Bit address |
| bit_op | input | 2 | 00 none, 01 set, 10 clear, 11 load |
| bit_wval | input | 1 | Bit value for a load |
| bit_rdata | output | 1 | Registered bit read data |
| push | input | 1 | Push request |
| push_data | input | 8 | Data to push |
| pop | input | 1 | Pop request |
| pop_data | output | 8 | Registered popped byte |
| sp | output | 7 | Stack pointer |

## Verification
The bench exercises the two ends of the bit window, bit address 00h and bit address 7Fh. A wrong shift or base offset would move these bits into bytes 1Fh or 30h. It writes to the same byte from the byte port and the bit port in one cycle, and also from the byte port and the register port. A wrong priority would leave the lower-priority value or a merged value in the byte.

It pushes past address 7Fh to check that the pointer wraps instead of sticking. It asserts push and pop together, where a design that let the pop act would move the pointer back or change `pop_data`. It reads and writes the same address in one cycle and expects the old value, and it changes the group bits to see that `ptr0` and `ptr1` follow them without delay.

// File: rtl/scram_pkg.sv
// Package scram_pkg: shared encodings for the banked scratch RAM.
// Assumes: the bit operation code arrives on a 2-bit port.
package scram_pkg;
    typedef enum logic [1:0] {
        BIT_NOP = 2'b00,
        BIT_SET = 2'b01,
        BIT_CLR = 2'b10,
        BIT_PUT = 2'b11
    } bit_op_e;
endpackage

// File: rtl/scram_bank_map.sv
// Module scram_bank_map: turns a register number into a byte address
// inside the register group chosen by status bits 4:3. It also gives
// the addresses of R0 and R1 of that group.
// Assumes: AW >= GRP_W + REG_W.
module scram_bank_map #(
    parameter int AW    = 7,
    parameter int REG_W = 3,
    parameter int GRP_W = 2,
    parameter int GRP_LSB = 3
) (
    input  logic [7:0]       status,
    input  logic [REG_W-1:0] reg_sel,
    output logic [AW-1:0]    reg_addr,
    output logic [AW-1:0]    r0_addr,
    output logic [AW-1:0]    r1_addr
);
    localparam int PAD = AW - GRP_W - REG_W;

    logic [GRP_W-1:0] grp;

    // Group select is taken straight from the status word.
    always_comb begin
        grp      = status[GRP_LSB +: GRP_W];
        reg_addr = {{PAD{1'b0}}, grp, reg_sel};
        r0_addr  = {{PAD{1'b0}}, grp, REG_W'(0)};
        r1_addr  = {{PAD{1'b0}}, grp, REG_W'(1)};
    end
endmodule

// File: rtl/scram_bit_map.sv
// Module scram_bit_map: folds a bit address onto the bit-addressable
// window. The upper bits pick the byte and the low three bits pick the bit.
// Assumes: the window starts at BIT_BASE and holds 2**(BIT_AW-3) bytes.
module scram_bit_map #(
    parameter int AW       = 7,
    parameter int BIT_AW   = 7,
    parameter int BIT_BASE = 32
) (
    input  logic [BIT_AW-1:0] bit_addr,
    output logic [AW-1:0]     bit_byte,
    output logic [2:0]        bit_pos
);
    // Byte index is the window base plus the upper bit-address field.
    always_comb begin
        bit_byte = AW'(BIT_BASE) + AW'(bit_addr[BIT_AW-1:3]);
        bit_pos  = bit_addr[2:0];
    end
endmodule

// File: rtl/scram_stack_ctl.sv
// Module scram_stack_ctl: holds the stack pointer. A push pre-increments
// it; a pop post-decrements it. A push beats a pop in the same cycle.
// Assumes: the RAM depth is 2**AW, so the pointer wraps naturally.
module scram_stack_ctl #(
    parameter int AW       = 7,
    parameter int SP_RESET = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] push_addr,
    output logic          pop_fire
);
    // The push target is the slot above the current top.
    always_comb begin
        push_addr = sp_q + AW'(1);
        pop_fire  = pop & ~push;
    end

    // Pointer register: increment on push, decrement on a lone pop.
    always_ff @(posedge clk) begin
        if (!rst_n)        sp_q <= AW'(SP_RESET);
        else if (push)     sp_q <= push_addr;
        else if (pop_fire) sp_q <= sp_q - AW'(1);
    end

    a_r8_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp_q == AW'($past(sp_q) + AW'(1)));
    a_r9_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> sp_q == AW'($past(sp_q) - AW'(1)));
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(sp_q));
endmodule

// File: rtl/scratch_ram_core.sv
// Module scratch_ram_core: a 128-byte internal RAM that can be reached by
// byte address, by register number, by bit address and through the stack.
// Every read is registered. All writes land on one clock edge, with the
// priority byte > register > push > bit.
// Assumes: DEPTH is a power of two, and the bit window lies inside the RAM.
module scratch_ram_core #(
    parameter int DEPTH     = 128,
    parameter int DW        = 8,
    parameter int BIT_BASE  = 32,
    parameter int BIT_BYTES = 16,
    parameter int SP_RESET  = 7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [7:0]                    status,
    input  logic [$clog2(DEPTH)-1:0]      byte_addr,
    input  logic                          byte_we,
    input  logic [DW-1:0]                 byte_wdata,
    output logic [DW-1:0]                 byte_rdata,
    input  logic [2:0]                    reg_sel,
    input  logic                          reg_we,
    input  logic [DW-1:0]                 reg_wdata,
    output logic [DW-1:0]                 reg_rdata,
    output logic [DW-1:0]                 ptr0,
    output logic [DW-1:0]                 ptr1,
    input  logic [$clog2(BIT_BYTES*8)-1:0] bit_addr,
    input  logic [1:0]                    bit_op,
    input  logic                          bit_wval,
    output logic                          bit_rdata,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 pop_data,
    output logic [$clog2(DEPTH)-1:0]      sp
);
    import scram_pkg::*;

    localparam int AW     = $clog2(DEPTH);
    localparam int BIT_AW = $clog2(BIT_BYTES * 8);

    logic [DW-1:0] mem_rd [DEPTH];
    logic [AW-1:0] reg_addr, r0_addr, r1_addr;
    logic [AW-1:0] bit_byte, push_addr;
    logic [2:0]    bit_pos;
    logic          pop_fire;
    bit_op_e       op;

    assign op = bit_op_e'(bit_op);

    scram_bank_map #(.AW(AW)) u_bank (
        .status(status), .reg_sel(reg_sel),
        .reg_addr(reg_addr), .r0_addr(r0_addr), .r1_addr(r1_addr)
    );

    scram_bit_map #(.AW(AW), .BIT_AW(BIT_AW), .BIT_BASE(BIT_BASE)) u_bit (
        .bit_addr(bit_addr), .bit_byte(bit_byte), .bit_pos(bit_pos)
    );

    scram_stack_ctl #(.AW(AW), .SP_RESET(SP_RESET)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .sp_q(sp), .push_addr(push_addr), .pop_fire(pop_fire)
    );

    // One storage cell per byte. Bytes inside the bit window also take bit operations.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        localparam logic [AW-1:0] IDX = AW'(i);
        localparam bit IN_WIN = (i >= BIT_BASE) && (i < BIT_BASE + BIT_BYTES);
        logic [DW-1:0] cell_q;
        logic [DW-1:0] bit_next;

        // Result of a bit operation applied to this byte's current value.
        always_comb begin
            bit_next = cell_q;
            case (op)
                BIT_SET: bit_next[bit_pos] = 1'b1;
                BIT_CLR: bit_next[bit_pos] = 1'b0;
                BIT_PUT: bit_next[bit_pos] = bit_wval;
                default: bit_next = cell_q;
            endcase
        end

        // Cell update, with the highest-priority writer first.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q <= '0;
            else if (byte_we && byte_addr == IDX)
                cell_q <= byte_wdata;
            else if (reg_we && reg_addr == IDX)
                cell_q <= reg_wdata;
            else if (push && push_addr == IDX)
                cell_q <= push_data;
            else if (IN_WIN && op != BIT_NOP && bit_byte == IDX)
                cell_q <= bit_next;
        end

        assign mem_rd[i] = cell_q;
    end

    // The pointer registers of the active group are shown combinationally.
    always_comb begin
        ptr0 = mem_rd[r0_addr];
        ptr1 = mem_rd[r1_addr];
    end

    // Registered read ports. They return the value from before this edge's writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_rdata <= '0;
            reg_rdata  <= '0;
            bit_rdata  <= 1'b0;
            pop_data   <= '0;
        end else begin
            byte_rdata <= mem_rd[byte_addr];
            reg_rdata  <= mem_rd[reg_addr];
            bit_rdata  <= mem_rd[bit_byte][bit_pos];
            if (pop_fire) pop_data <= mem_rd[sp];
        end
    end

    a_r2_byte_store: assert property (@(posedge clk) disable iff (!rst_n)
        byte_we |=> mem_rd[$past(byte_addr)] == $past(byte_wdata));
    a_r3_reg_store: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !byte_we) |=> mem_rd[$past(reg_addr)] == $past(reg_wdata));
    a_r8_push_store: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !byte_we && !reg_we) |=> mem_rd[sp] == $past(push_data));
    a_r6_bit_local: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_op != 2'b00 && !byte_we && !reg_we && !push) |=>
        $countones(mem_rd[$past(bit_byte)] ^ $past(mem_rd[bit_byte])) <= 1);
    a_r11_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> $stable(pop_data));
endmodule

// File: tb/scratch_ram_core_tb.sv
// Bench for scratch_ram_core: a behavioural reference model that is
// stepped every clock and compared with all outputs at the falling edge.
module scratch_ram_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] status = '0;
    logic [6:0] byte_addr = '0;
    logic       byte_we = 1'b0;
    logic [7:0] byte_wdata = '0;
    logic [7:0] byte_rdata;
    logic [2:0] reg_sel = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, ptr0, ptr1;
    logic [6:0] bit_addr = '0;
    logic [1:0] bit_op = '0;
    logic       bit_wval = 1'b0;
    logic       bit_rdata;
    logic       push = 1'b0, pop = 1'b0;
    logic [7:0] push_data = '0;
    logic [7:0] pop_data;
    logic [6:0] sp;

    int checks = 0, errors = 0;
    bit done = 0;
    string phase = "R1";

    logic [7:0] mdl [128];
    logic [7:0] nxt [128];
    int         msp;
    logic [7:0] e_byte, e_reg, e_pop;
    logic       e_bit;

    always #10 clk = ~clk;

    scratch_ram_core u_dut (
        .clk(clk), .rst_n(rst_n), .status(status),
        .byte_addr(byte_addr), .byte_we(byte_we), .byte_wdata(byte_wdata),
        .byte_rdata(byte_rdata), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ptr0(ptr0), .ptr1(ptr1),
        .bit_addr(bit_addr), .bit_op(bit_op), .bit_wval(bit_wval),
        .bit_rdata(bit_rdata), .push(push), .push_data(push_data), .pop(pop),
        .pop_data(pop_data), .sp(sp)
    );

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s/%s at %0t: got %h expected %h", req, phase, $time, act, exp);
        end
    endtask

    task automatic idle();
        byte_we = 0; reg_we = 0; bit_op = 2'b00; push = 0; pop = 0;
    endtask

    // One clock: update the model at the edge, then compare at the falling edge.
    task automatic step();
        int ra, bb, bp;
        @(posedge clk);
        if (!rst_n) begin
            foreach (mdl[i]) mdl[i] = 8'h00;
            msp = 7; e_byte = 0; e_reg = 0; e_bit = 0; e_pop = 0;
        end else begin
            ra = status[4:3] * 8 + int'(reg_sel);
            bb = 32 + int'(bit_addr) / 8;
            bp = int'(bit_addr) % 8;
            e_byte = mdl[byte_addr];
            e_reg  = mdl[ra];
            e_bit  = mdl[bb][bp];
            if (pop && !push) e_pop = mdl[msp];
            nxt = mdl;
            case (bit_op)
                2'b01: nxt[bb][bp] = 1'b1;
                2'b10: nxt[bb][bp] = 1'b0;
                2'b11: nxt[bb][bp] = bit_wval;
                default: ;
            endcase
            if (push)    nxt[(msp + 1) % 128] = push_data;
            if (reg_we)  nxt[ra] = reg_wdata;
            if (byte_we) nxt[byte_addr] = byte_wdata;
            mdl = nxt;
            if (push)     msp = (msp + 1) % 128;
            else if (pop) msp = (msp + 127) % 128;
        end
        @(negedge clk);
        chk("R2", byte_rdata, e_byte);
        chk("R3", reg_rdata, e_reg);
        chk("R5", {7'b0, bit_rdata}, {7'b0, e_bit});
        chk("R9", pop_data, e_pop);
        chk("R8", {1'b0, sp}, 8'(msp));
        chk("R4", ptr0, mdl[status[4:3] * 8]);
        chk("R4", ptr1, mdl[status[4:3] * 8 + 1]);
    endtask

    task automatic rd_byte(logic [6:0] a);
        idle(); byte_addr = a; step();
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset values, then every byte reads zero.
        phase = "R1";
        repeat (2) step();
        @(negedge clk); rst_n = 1'b1;
        step();
        for (int i = 0; i < 128; i++) rd_byte(7'(i));

        // R2: fill the whole RAM, read it back, then read and write the same address.
        phase = "R2";
        for (int i = 0; i < 128; i++) begin
            idle(); byte_we = 1; byte_addr = 7'(i); byte_wdata = 8'(i * 37 + 5); step();
        end
        for (int i = 0; i < 128; i++) rd_byte(7'(i));
        idle(); byte_we = 1; byte_addr = 7'h44; byte_wdata = 8'hC3; step();
        rd_byte(7'h44);

        // R3 / R4: write each register of each group, then read it back.
        phase = "R3";
        for (int g = 0; g < 4; g++) begin
            status = 8'(g << 3) | 8'hA7 & 8'hE7;
            for (int n = 0; n < 8; n++) begin
                idle(); reg_we = 1; reg_sel = 3'(n); reg_wdata = 8'(g * 16 + n + 8'h90); step();
            end
            for (int n = 0; n < 8; n++) begin
                idle(); reg_sel = 3'(n); step();
            end
        end
        phase = "R4";
        for (int g = 3; g >= 0; g--) begin
            idle(); status = 8'(g << 3); step();
        end

        // R5 / R6: the edges of the bit window, and each operation code.
        phase = "R6";
        status = 8'h00;
        idle(); byte_we = 1; byte_addr = 7'h20; byte_wdata = 8'h00; step();
        idle(); byte_we = 1; byte_addr = 7'h2F; byte_wdata = 8'hFF; step();
        idle(); bit_op = 2'b01; bit_addr = 7'h00; step();
        idle(); bit_op = 2'b10; bit_addr = 7'h7F; step();
        idle(); bit_op = 2'b11; bit_addr = 7'h45; bit_wval = 1'b0; step();
        idle(); bit_op = 2'b11; bit_addr = 7'h46; bit_wval = 1'b1; step();
        rd_byte(7'h20); rd_byte(7'h2F); rd_byte(7'h28); rd_byte(7'h1F); rd_byte(7'h30);
        phase = "R5";
        for (int b = 0; b < 128; b += 9) begin
            idle(); bit_addr = 7'(b); step();
        end

        // R12: code 00 leaves the byte alone, whatever bit_wval is.
        phase = "R12";
        idle(); bit_op = 2'b00; bit_addr = 7'h18; bit_wval = 1'b1; step();
        idle(); bit_op = 2'b00; bit_addr = 7'h19; bit_wval = 1'b0; step();
        rd_byte(7'h23);

        // R7: several writers on one byte in the same cycle.
        phase = "R7";
        idle(); byte_we = 1; byte_addr = 7'h25; byte_wdata = 8'h5A;
        bit_op = 2'b01; bit_addr = 7'h28; step();
        rd_byte(7'h25);
        idle(); byte_we = 1; byte_addr = 7'h03; byte_wdata = 8'h11;
        reg_we = 1; reg_sel = 3'd3; reg_wdata = 8'h22; step();
        rd_byte(7'h03);

        // R8 / R9: push a few bytes, then pop them.
        phase = "R8";
        for (int i = 0; i < 5; i++) begin
            idle(); push = 1; push_data = 8'(8'hB0 + i); step();
        end
        phase = "R9";
        for (int i = 0; i < 6; i++) begin
            idle(); pop = 1; step();
        end
        idle(); step();

        // R10: push past 7Fh, then pop back across it.
        phase = "R10";
        for (int i = 0; i < 130; i++) begin
            idle(); push = 1; push_data = 8'(i); step();
        end
        for (int i = 0; i < 10; i++) begin
            idle(); pop = 1; step();
        end
        idle(); status = 8'h00; step();

        // R11: push and pop together.
        phase = "R11";
        idle(); push = 1; pop = 1; push_data = 8'hEE; step();
        idle(); push = 1; pop = 1; push_data = 8'hDD; step();
        idle(); pop = 1; step();

        // Mixed traffic on every port.
        phase = "R2";
        for (int i = 0; i < 2000; i++) begin
            idle();
            status = 8'($urandom);
            byte_addr = 7'($urandom); byte_we = ($urandom % 4) == 0; byte_wdata = 8'($urandom);
            reg_sel = 3'($urandom); reg_we = ($urandom % 4) == 0; reg_wdata = 8'($urandom);
            bit_addr = 7'($urandom); bit_op = 2'($urandom); bit_wval = 1'($urandom);
            push = ($urandom % 6) == 0; pop = ($urandom % 6) == 0; push_data = 8'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule